// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a byte-wide serial EEPROM on a two-wire bus (I2C). It runs on a fast system clock that oversamples the bus clock and data lines. It detects start and stop conditions and decodes a select byte. Depending on the capacity parameter, some of the chip-enable positions in that byte carry upper memory address bits instead. It accepts one address byte, byte writes and page writes. It serves current-address, random-address and sequential reads from an internal register array.

Page-write data collects in a 16-byte buffer. A stop that follows at least one accepted data byte starts a self-timed write cycle. That cycle copies the buffer into the array and lasts a parameterised number of system clocks. During the cycle the block ignores the bus, so a master can find the end of the cycle by sending its select byte until it is acknowledged. A write-protect input lets the select and address bytes through but refuses every data byte. The data line is driven only as an open-drain pull-down enable.

Top module: `ee2w_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start. A start outside the write cycle always begins a new select byte, even in the middle of a byte. A rising data line while the clock is high is a stop, and it returns the block to standby. In standby, bits sent without a start get no acknowledge.
- R2: Data bits are sampled on the rising bus clock, most significant bit first. A select byte is acknowledged only if its bits 7:4 are 1010. Bit 0 of the select byte is 1 for read and 0 for write.
- R3: Select bits 3:1 are compared with chip_en_i[2:0]. Bits taken as address are skipped: bit 1 at 4 Kbit, bits 2:1 at 8 Kbit, and all three at 16 Kbit. On a mismatch the block gives no acknowledge and stays released until the next start.
- R4: The address byte is acknowledged. The full address is the select-byte address bits (bit 1 = A8, bit 2 = A9, bit 3 = A10) joined to the address byte.
- R5: Up to 16 data bytes are acknowledged and buffered. The low 4 address bits advance after each byte and wrap inside the 16-byte page, so later bytes overwrite earlier ones at the same position.
- R6: While wp_i is high, data bytes get no acknowledge and leave the memory unchanged. The select and address bytes are still acknowledged.
- R7: A stop after at least one acknowledged data byte starts a write cycle of WR_CYCLES clocks. A transfer that ends before any data byte is complete starts no write cycle.
- R8: While the write cycle runs, starts are not detected and the select byte is not acknowledged.
- R9: In a read, each byte comes from the address counter, which then advances across the whole array and wraps from the last byte to 0. A read with no address byte continues from the current counter.
- R10: A repeated start after the address byte, followed by a read select, reads from that address.
- R11: A master NoAck ends the read: the block releases the data line and waits for a stop or start.
- R12: sda_oe_o changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| chip_en_i | input | 3 | Chip-enable strap value compared with the select byte |
| wp_i | input | 1 | High refuses all data bytes |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
Two instances share one wired-AND bus: a 2 Kbit part strapped to 000 and an 8 Kbit part strapped to 1xx. A sweep over all eight select codes shows whether each chip-enable position is compared or taken as an address bit. A 20-byte page write starting at page offset 12 gives values that show whether the offset wraps and whether the last byte written to a position wins. Reads at 0xFE, 0xFF and 0x00 separate wrap of the whole array from wrap inside a page. Writing the same low address under two different select codes separates the address bits carried in the select byte. Sending the select byte right after a stop separates busy, protected and aborted writes.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    localparam int PAGE_BYTES = 16;
    localparam int PAGE_AW    = $clog2(PAGE_BYTES);

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_MACK,
        S_WCYC
    } ee2w_state_e;

endpackage

// File: rtl/ee2w_linesync.sv
module ee2w_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] scl_d, scl_q;
    logic [TOP:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[TOP-1:0], scl_i};
        sda_d = {sda_q[TOP-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // the newest synchronised sample and the one before it
    assign sda_o   = sda_q[TOP-1];
    assign rise_o  = scl_q[TOP-1] & ~scl_q[TOP];
    assign fall_o  = ~scl_q[TOP-1] & scl_q[TOP];
    assign start_o = scl_q[TOP-1] & scl_q[TOP] & sda_q[TOP] & ~sda_q[TOP-1];
    assign stop_o  = scl_q[TOP-1] & scl_q[TOP] & ~sda_q[TOP] & sda_q[TOP-1];

endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int CAP_KBIT    = 2,
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_en_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int DEPTH   = CAP_KBIT * 128;
    localparam int AW      = $clog2(DEPTH);
    localparam int HI_BITS = (AW > 8) ? AW - 8 : 0;
    localparam logic [2:0] HI_MASK = 3'((1 << HI_BITS) - 1);
    localparam int WCW     = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        ee2w_state_e                  st;
        logic [2:0]                   cnt;
        logic                         done;
        logic                         rd;
        logic [7:0]                   sh;
        logic [2:0]                   hi;
        logic [AW-1:0]                addr;
        logic                         oe;
        logic [PAGE_BYTES-1:0][7:0]   pbuf;
        logic [PAGE_BYTES-1:0]        pval;
        logic [WCW-1:0]               wcnt;
    } regs_t;

    regs_t q, n;

    logic sda_s, rise, fall, start, stop;
    logic [7:0] rdata;
    logic       mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0] mem_wdata;
    logic       sel_ok, byte_end;

    ee2w_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
        .start_o(start), .stop_o(stop)
    );

    ee2w_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(q.addr), .rdata(rdata)
    );

    always_comb begin
        n         = q;
        sel_ok    = (q.sh[7:4] == 4'b1010) &&
                    (((q.sh[3:1] ^ chip_en_i) & ~HI_MASK) == 3'b000);
        byte_end  = fall && q.done;
        mem_we    = 1'b0;
        mem_waddr = {q.addr[AW-1:PAGE_AW], q.wcnt[PAGE_AW-1:0]};
        mem_wdata = q.pbuf[q.wcnt[PAGE_AW-1:0]];

        if (q.st == S_WCYC) begin
            // bus is ignored; buffered page is copied out first
            mem_we = (q.wcnt < WCW'(PAGE_BYTES)) && q.pval[q.wcnt[PAGE_AW-1:0]];
            if (q.wcnt == WCW'(WR_CYCLES - 1)) begin
                n.st   = S_IDLE;
                n.pval = '0;
                n.wcnt = '0;
            end else begin
                n.wcnt = q.wcnt + WCW'(1);
            end
        end else if (start) begin
            n.st   = S_DEV;
            n.cnt  = '0;
            n.done = 1'b0;
            n.oe   = 1'b0;
            n.pval = '0;
        end else if (stop) begin
            n.oe   = 1'b0;
            n.done = 1'b0;
            if ((q.st == S_WDATA || q.st == S_WDATA_ACK) && (|q.pval)) begin
                n.st   = S_WCYC;
                n.wcnt = '0;
            end else begin
                n.st = S_IDLE;
            end
        end else begin
            if ((q.st inside {S_DEV, S_ADDR, S_WDATA}) && rise) begin
                n.sh   = {q.sh[6:0], sda_s};
                n.cnt  = q.cnt + 3'd1;
                n.done = (q.cnt == 3'd7);
            end
            if (byte_end) begin
                n.done = 1'b0;
                n.cnt  = '0;
            end
            case (q.st)
                S_DEV: if (byte_end) begin
                    if (sel_ok) begin
                        n.oe = 1'b1;
                        n.st = S_DEV_ACK;
                        n.rd = q.sh[0];
                        n.hi = q.sh[3:1] & HI_MASK;
                    end else begin
                        n.st = S_IDLE;
                    end
                end
                S_ADDR: if (byte_end) begin
                    n.addr = AW'({q.hi, q.sh});
                    n.oe   = 1'b1;
                    n.pval = '0;
                    n.st   = S_ADDR_ACK;
                end
                S_WDATA: if (byte_end) begin
                    if (!wp_i) begin
                        n.oe = 1'b1;
                        n.pbuf[q.addr[PAGE_AW-1:0]] = q.sh;
                        n.pval[q.addr[PAGE_AW-1:0]] = 1'b1;
                        n.addr[PAGE_AW-1:0] = q.addr[PAGE_AW-1:0] + PAGE_AW'(1);
                    end
                    n.st = S_WDATA_ACK;
                end
                S_DEV_ACK: if (fall) begin
                    n.oe = 1'b0;
                    if (q.rd) begin
                        n.sh   = rdata;
                        n.oe   = ~rdata[7];
                        n.cnt  = '0;
                        n.addr = q.addr + AW'(1);
                        n.st   = S_TX;
                    end else begin
                        n.st = S_ADDR;
                    end
                end
                S_ADDR_ACK, S_WDATA_ACK: if (fall) begin
                    n.oe = 1'b0;
                    n.st = S_WDATA;
                end
                S_TX: if (fall) begin
                    if (q.cnt == 3'd7) begin
                        n.oe   = 1'b0;
                        n.done = 1'b0;
                        n.st   = S_MACK;
                    end else begin
                        n.sh  = {q.sh[6:0], 1'b0};
                        n.oe  = ~q.sh[6];
                        n.cnt = q.cnt + 3'd1;
                    end
                end
                S_MACK: begin
                    if (rise) begin
                        if (sda_s) n.st = S_IDLE;
                        else       n.done = 1'b1;
                    end else if (byte_end) begin
                        n.done = 1'b0;
                        n.sh   = rdata;
                        n.oe   = ~rdata[7];
                        n.cnt  = '0;
                        n.addr = q.addr + AW'(1);
                        n.st   = S_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe_o = q.oe;

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WCYC) |-> !sda_oe_o); // R8
    AST_WP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WDATA && byte_end && wp_i) |=> !sda_oe_o); // R6
    AST_WP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WDATA && byte_end && wp_i) |=> $stable(q.pval)); // R6
    AST_STOP_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && (q.st == S_WDATA || q.st == S_WDATA_ACK) && (|q.pval)) |=> (q.st == S_WCYC)); // R7
    AST_NO_EMPTY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == S_WCYC) |-> (|q.pval)); // R7
    AST_SELECT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DEV && byte_end && !sel_ok) |=> (!sda_oe_o && q.st == S_IDLE)); // R3
    AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(fall || start || stop)); // R12

endmodule

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;

    localparam int CLK_NS = 10;
    localparam int Q      = 8;
    localparam int WRC    = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic oe0, oe1;
    logic sda;

    int nchk = 0;
    int nerr = 0;
    int viol = 0;
    logic [1:0] oe_prev = 2'b00;
    logic [7:0] rbuf [16];
    logic [7:0] expv [16];

    always #(CLK_NS / 2) clk = ~clk;

    assign sda = m_sda & ~oe0 & ~oe1;

    ee2w_slave #(.CAP_KBIT(2), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
        .chip_en_i(3'b000), .wp_i(wp), .sda_oe_o(oe0)
    );

    ee2w_slave #(.CAP_KBIT(8), .WR_CYCLES(WRC)) uut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
        .chip_en_i(3'b100), .wp_i(1'b0), .sda_oe_o(oe1)
    );

    // R12 monitor: pull-down may move only while the bus clock is low
    always @(negedge clk) begin
        if (rst_n && ({oe0, oe1} !== oe_prev) && m_scl) viol++;
        oe_prev <= {oe0, oe1};
    end

    task automatic wq(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bstart();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic set_addr(input logic [7:0] sel, input logic [7:0] a, input string req);
        logic ack;
        bstart();
        send_byte(sel, ack);
        chk(ack, req, "select ack", ack, 1);
        send_byte(a, ack);
        chk(ack, req, "address ack", ack, 1);
    endtask

    // random read of n bytes starting at a, last byte NoAck'd
    task automatic read_run(input logic [7:0] sel, input logic [7:0] a, input int cnt);
        logic ack;
        set_addr(sel, a, "R10");
        bstart();
        send_byte(sel | 8'h01, ack);
        chk(ack, "R10", "read select ack", ack, 1);
        for (int i = 0; i < cnt; i++) recv_byte(i != cnt - 1, rbuf[i]);
        chk(!oe0 && !oe1, "R11", "released after NoAck", {oe0, oe1}, 0);
        bstop();
    endtask

    task automatic poll(input logic [7:0] sel, output int tries);
        logic ack;
        tries = 0;
        do begin
            bstart();
            send_byte(sel, ack);
            bstop();
            tries++;
        end while (!ack && tries < 20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int tries;

        wq(4);
        chk(!oe0 && !oe1, "R12", "reset released", {oe0, oe1}, 0);
        rst_n = 1'b1;
        wq(4);
        chk(!oe0 && !oe1, "R1", "standby after reset", {oe0, oe1}, 0);

        // R3 sweep over all select-code chip-enable values
        for (int e = 0; e < 8; e++) begin
            bstart();
            send_byte(8'hA0 | 8'(e << 1), ack);
            bstop();
            chk(ack == ((e == 0) || (e >= 4)), "R3", $sformatf("select e=%0d ack", e),
                ack, (e == 0) || (e >= 4));
        end
        bstart();
        send_byte(8'hB0, ack);
        bstop();
        chk(!ack, "R2", "wrong type nibble ack", ack, 0);

        // R1: bits in standby without a start are ignored
        send_byte(8'hA0, ack);
        chk(!ack, "R1", "no start ack", ack, 0);
        // R1: start in the middle of a byte restarts
        bstart();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bstart();
        send_byte(8'hA0, ack);
        bstop();
        chk(ack, "R1", "restart mid byte ack", ack, 1);

        // byte write then busy poll
        set_addr(8'hA0, 8'h10, "R4");
        send_byte(8'h5A, ack);
        chk(ack, "R5", "data ack", ack, 1);
        bstop();
        poll(8'hA0, tries);
        chk(tries >= 2, "R8", "busy select refused", tries, 2);
        chk(tries < 8, "R7", "cycle ends", tries, 2);
        read_run(8'hA0, 8'h10, 1);
        chk(rbuf[0] == 8'h5A, "R10", "random read 0x10", rbuf[0], 8'h5A);

        // page write from offset 12 with 20 bytes: wraps and overwrites
        set_addr(8'hA0, 8'h2C, "R5");
        for (int k = 0; k < 20; k++) begin
            send_byte(8'h30 + 8'(k), ack);
            chk(ack, "R5", "page byte ack", ack, 1);
            expv[(12 + k) % 16] = 8'h30 + 8'(k);
        end
        bstop();
        poll(8'hA0, tries);
        read_run(8'hA0, 8'h20, 16);
        for (int i = 0; i < 16; i++)
            chk(rbuf[i] == expv[i], "R5", $sformatf("page entry %0d", i), rbuf[i], expv[i]);

        // array wrap: 0xFE, 0xFF, 0x00
        set_addr(8'hA0, 8'hFE, "R9");
        send_byte(8'hE1, ack);
        send_byte(8'hE2, ack);
        bstop();
        poll(8'hA0, tries);
        set_addr(8'hA0, 8'h00, "R9");
        send_byte(8'hE3, ack);
        bstop();
        poll(8'hA0, tries);
        read_run(8'hA0, 8'hFE, 1);
        chk(rbuf[0] == 8'hE1, "R9", "read 0xFE", rbuf[0], 8'hE1);
        bstart();
        send_byte(8'hA1, ack);
        chk(ack, "R9", "current read select", ack, 1);
        recv_byte(1'b1, v);
        chk(v == 8'hE2, "R9", "current read 0xFF", v, 8'hE2);
        recv_byte(1'b0, v);
        chk(v == 8'hE3, "R9", "wrap to 0x00", v, 8'hE3);
        bstop();

        // R6 write protect
        wp = 1'b1;
        set_addr(8'hA0, 8'h10, "R6");
        send_byte(8'h77, ack);
        chk(!ack, "R6", "protected data ack", ack, 0);
        bstop();
        wp = 1'b0;
        bstart();
        send_byte(8'hA0, ack);
        bstop();
        chk(ack, "R7", "no cycle after refused data", ack, 1);
        read_run(8'hA0, 8'h10, 1);
        chk(rbuf[0] == 8'h5A, "R6", "memory unchanged", rbuf[0], 8'h5A);

        // R7 abort after address byte
        set_addr(8'hA0, 8'h40, "R7");
        bstop();
        bstart();
        send_byte(8'hA0, ack);
        bstop();
        chk(ack, "R7", "no cycle after abort", ack, 1);

        // R4 upper address bits in the select byte (8 Kbit part)
        set_addr(8'hAC, 8'h05, "R4");
        send_byte(8'h91, ack);
        bstop();
        poll(8'hA8, tries);
        set_addr(8'hA8, 8'h05, "R4");
        send_byte(8'h19, ack);
        bstop();
        poll(8'hA8, tries);
        read_run(8'hAC, 8'h05, 1);
        chk(rbuf[0] == 8'h91, "R4", "A9:A8=2 byte", rbuf[0], 8'h91);
        read_run(8'hA8, 8'h05, 1);
        chk(rbuf[0] == 8'h19, "R4", "A9:A8=0 byte", rbuf[0], 8'h19);

        chk(viol == 0, "R12", "pull-down moved while clock high", viol, 0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule